// File: doc/BRIEF.md
# Register-Controlled GPIO Port with Pin-Change Interrupts

The block is an eight-pin general-purpose I/O port that software controls through a small byte-wide register bus. The bus has a 5-bit address, a write strobe, write data and combinational read data. Software sets the pin directions and output levels either by writing a whole register or through set, clear and toggle aliases. Each alias changes only the bits written as 1, so one pin can be updated without a read-modify-write sequence.

Each pin input passes through a two-stage synchronizer. It can then be inverted, or gated off by its pin control byte. Each pin has its own sense condition: any change, a rising edge, a falling edge, or a low level. Two interrupt channels each select pins through their own mask. Each channel latches a sticky flag that software clears by writing 1 to it. Each channel also has a 2-bit level field, which gates its interrupt output and is exported for the chip's interrupt controller.

Drive/pull selection and slew-rate limiting are only stored. They are exported per pin to the pad ring.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0 at every address 0x00 to 0x17. All pins are inputs (`pin_oe` = 0), `pin_out` = 0 and both `irq` bits are 0.
- R2: A write to 0x00 (direction) or 0x04 (output) loads the whole byte. `pin_oe` equals the direction register. `pin_out` equals the output register XOR the per-pin invert bits.
- R3: Writes to 0x01/0x05 (set), 0x02/0x06 (clear) and 0x03/0x07 (toggle) change only the bits where the write data is 1. Reading an alias returns the base register.
- R4: Reading 0x08 returns the pin inputs after two clock edges of synchronization, XOR the invert bit (bit 6 of the pin control byte). A pin whose sense field (bits [2:0]) is 4 to 7 reads 0.
- R5: Sense field values are 0 = any change, 1 = rising, 2 = falling and 3 = low level. Once the input value at 0x08 shows the condition, the channel flag is set at the next clock edge. A rising-edge pin ignores falling edges.
- R6: Channel 0 uses the mask at 0x0A and channel 1 uses the mask at 0x0B. A sense event on a pin that is not in a channel's mask does not set that channel's flag.
- R7: The flag register at 0x0C holds channel 0 in bit 0 and channel 1 in bit 1. A flag stays set until 1 is written to its bit. A flag cleared while its sense event is still present stays set.
- R8: Interrupt control at 0x09 holds the channel 0 level in bits [1:0] and the channel 1 level in bits [3:2]; bits [7:4] read 0. `irq[n]` is high exactly when flag n is set and its level is nonzero. `irq_level` exports the 4-bit control field.
- R9: Pin n's control byte is at 0x10+n. It reads back whole. Bits [5:3] appear on `pin_pull_mode[3n+2:3n]` and bit 7 appears on `pin_slew_lim[n]`.
- R10: Writes to 0x08 and to unmapped addresses have no effect, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_addr | input | 5 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Pad output levels after inversion |
| pin_oe | output | 8 | Pad output enables (1 = output) |
| pin_pull_mode | output | 24 | Per-pin drive/pull code, 3 bits per pin |
| pin_slew_lim | output | 8 | Per-pin slew-rate limit enable |
| irq | output | 2 | Interrupt request per channel |
| irq_level | output | 4 | Channel levels, {ch1, ch0} |

## Verification
Register writes take effect at the clock edge that samples the strobe. Read data is combinational, so the bench reads half a cycle after the write edge. A pin change driven between edges reaches 0x08 after the second following edge and the flag after the third. `irq` follows the flag combinationally. The bench samples one cycle early to see the old value and then at the due cycle, so an extra or missing register stage is reported. Rejected events are checked after a longer quiet window.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned NPIN  = 8;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 5;
  localparam int unsigned NCHAN = 2;

  // register offsets (fixed by the software map)
  localparam logic [AW-1:0] OFS_DIR    = 5'h00;
  localparam logic [AW-1:0] OFS_OUT    = 5'h04;
  localparam logic [AW-1:0] OFS_IN     = 5'h08;
  localparam logic [AW-1:0] OFS_ICTL   = 5'h09;
  localparam logic [AW-1:0] OFS_MASK0  = 5'h0A;
  localparam logic [AW-1:0] OFS_MASK1  = 5'h0B;
  localparam logic [AW-1:0] OFS_FLAGS  = 5'h0C;
  localparam logic [AW-1:0] OFS_PCTL   = 5'h10;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TGL  = 2'd3
  } alias_op_t;

  localparam logic [2:0] SNS_ANY  = 3'd0;
  localparam logic [2:0] SNS_RISE = 3'd1;
  localparam logic [2:0] SNS_FALL = 3'd2;
  localparam logic [2:0] SNS_LOW  = 3'd3;

  typedef struct packed {
    logic       slew;
    logic       inv;
    logic [2:0] drive;
    logic [2:0] sense;
  } pinctl_t;

  function automatic logic [DW-1:0] alias_apply(
    input alias_op_t     op,
    input logic [DW-1:0] cur,
    input logic [DW-1:0] d
  );
    logic [DW-1:0] r;
    unique case (op)
      OP_LOAD: r = d;
      OP_SET:  r = cur | d;
      OP_CLR:  r = cur & ~d;
      default: r = cur ^ d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [AW-1:0]               addr,
  input  logic [DW-1:0]               wdata,
  output logic [NPIN-1:0]             dir_q,
  output logic [NPIN-1:0]             out_q,
  output logic [3:0]                  ictl_q,
  output logic [NCHAN-1:0][NPIN-1:0]  mask_q,
  output pinctl_t [NPIN-1:0]          pctl_q
);

  logic              dir_en, out_en, ictl_en;
  logic [NPIN-1:0]   dir_d, out_d;
  logic [NCHAN-1:0]  mask_en;
  logic [NPIN-1:0]   pctl_en;
  alias_op_t         op;

  // next-state
  always_comb begin
    op      = alias_op_t'(addr[1:0]);
    dir_en  = we && (addr[AW-1:2] == OFS_DIR[AW-1:2]);
    out_en  = we && (addr[AW-1:2] == OFS_OUT[AW-1:2]);
    ictl_en = we && (addr == OFS_ICTL);
    dir_d   = alias_apply(op, dir_q, wdata);
    out_d   = alias_apply(op, out_q, wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      ictl_q <= '0;
    end else begin
      if (dir_en)  dir_q  <= dir_d;
      if (out_en)  out_q  <= out_d;
      if (ictl_en) ictl_q <= wdata[3:0];
    end
  end

  for (genvar c = 0; c < NCHAN; c++) begin : g_mask
    always_comb mask_en[c] = we && (addr == OFS_MASK0 + AW'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q[c] <= '0;
      else if (mask_en[c]) mask_q[c] <= wdata;
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pctl
    always_comb pctl_en[p] = we && (addr == OFS_PCTL + AW'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pctl_q[p] <= '0;
      else if (pctl_en[p]) pctl_q[p] <= pinctl_t'(wdata);
    end
  end

endmodule

// File: rtl/gpio_port_sense.sv
module gpio_port_sense
  import gpio_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPIN-1:0]    pin_in,
  input  pinctl_t [NPIN-1:0] pctl,
  output logic [NPIN-1:0]    in_val,
  output logic [NPIN-1:0]    hit
);

  localparam int unsigned TOP = SYNC_STAGES - 1;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   enabled;
    logic                   cur;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in[p]};
    end

    always_comb begin
      enabled   = ~pctl[p].sense[2];
      cur       = enabled & (sync_q[TOP] ^ pctl[p].inv);
      in_val[p] = cur;
      unique case (pctl[p].sense)
        SNS_ANY:  hit[p] = cur ^ prev_q;
        SNS_RISE: hit[p] = cur & ~prev_q;
        SNS_FALL: hit[p] = ~cur & prev_q;
        SNS_LOW:  hit[p] = ~cur;
        default:  hit[p] = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur;
    end
  end

endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
  import gpio_port_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPIN-1:0]            hit,
  input  logic [NCHAN-1:0][NPIN-1:0] mask,
  input  logic [NCHAN-1:0]           clr,
  input  logic [3:0]                 ictl,
  output logic [NCHAN-1:0]           flag_q,
  output logic [NCHAN-1:0]           irq
);

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    logic event_c;
    logic flag_d;
    logic flag_en;

    always_comb begin
      event_c = |(hit & mask[c]);
      flag_en = event_c | clr[c];
      flag_d  = event_c;          // event wins over a clear
      irq[c]  = flag_q[c] & (|ictl[2*c +: 2]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q[c] <= 1'b0;
      else if (flag_en) flag_q[c] <= flag_d;
    end
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       bus_addr,
  input  logic             bus_we,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [7:0]       pin_in,
  output logic [7:0]       pin_out,
  output logic [7:0]       pin_oe,
  output logic [23:0]      pin_pull_mode,
  output logic [7:0]       pin_slew_lim,
  output logic [1:0]       irq,
  output logic [3:0]       irq_level
);

  logic [NPIN-1:0]            dir_q, out_q, in_val, hit, inv_v;
  logic [3:0]                 ictl_q;
  logic [NCHAN-1:0][NPIN-1:0] mask_q;
  pinctl_t [NPIN-1:0]         pctl_q;
  logic [NCHAN-1:0]           flag_q, flag_clr;

  gpio_port_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (bus_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .dir_q  (dir_q),
    .out_q  (out_q),
    .ictl_q (ictl_q),
    .mask_q (mask_q),
    .pctl_q (pctl_q)
  );

  gpio_port_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .pctl   (pctl_q),
    .in_val (in_val),
    .hit    (hit)
  );

  always_comb flag_clr = (bus_we && bus_addr == OFS_FLAGS) ? bus_wdata[NCHAN-1:0] : '0;

  gpio_port_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .mask   (mask_q),
    .clr    (flag_clr),
    .ictl   (ictl_q),
    .flag_q (flag_q),
    .irq    (irq)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pad
    always_comb begin
      inv_v[p]              = pctl_q[p].inv;
      pin_pull_mode[3*p +: 3] = pctl_q[p].drive;
      pin_slew_lim[p]       = pctl_q[p].slew;
    end
  end

  always_comb begin
    pin_oe    = dir_q;
    pin_out   = out_q ^ inv_v;
    irq_level = ictl_q;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr[4]) begin
      if (bus_addr[3] == 1'b0) bus_rdata = pctl_q[bus_addr[2:0]];
    end else if (bus_addr[3:2] == 2'b00) begin
      bus_rdata = dir_q;
    end else if (bus_addr[3:2] == 2'b01) begin
      bus_rdata = out_q;
    end else begin
      unique case (bus_addr)
        OFS_IN:    bus_rdata = in_val;
        OFS_ICTL:  bus_rdata = {4'b0, ictl_q};
        OFS_MASK0: bus_rdata = mask_q[0];
        OFS_MASK1: bus_rdata = mask_q[1];
        OFS_FLAGS: bus_rdata = {{(DW-NCHAN){1'b0}}, flag_q};
        default:   bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [4:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  pin_oe,
  input logic [23:0] pin_pull_mode,
  input logic [1:0]  irq,
  input logic [3:0]  irq_level,
  input logic [1:0]  flag_q
);

  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'h00) |=> pin_oe == $past(bus_wdata));

  // R3
  dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'h01) |=> pin_oe == ($past(pin_oe) | $past(bus_wdata)));

  // R3
  dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'h02) |=> pin_oe == ($past(pin_oe) & ~$past(bus_wdata)));

  // R7
  flag0_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !(bus_we && bus_addr == 5'h0C && bus_wdata[0])) |=> flag_q[0]);

  // R7
  flag1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && !(bus_we && bus_addr == 5'h0C && bus_wdata[1])) |=> flag_q[1]);

  // R8
  irq0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level[1:0] == 2'b00) |-> !irq[0]);

  // R8
  irq1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level[3:2] == 2'b00) |-> !irq[1]);

  // R9
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr[4:3] == 2'b10) |=> $stable(pin_pull_mode));

endmodule

bind gpio_port gpio_port_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .pin_oe        (pin_oe),
  .pin_pull_mode (pin_pull_mode),
  .irq           (irq),
  .irq_level     (irq_level),
  .flag_q        (flag_q)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe, pin_slew_lim;
  logic [23:0] pin_pull_mode;
  logic [1:0]  irq;
  logic [3:0]  irq_level;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  gpio_port u_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pull_mode(pin_pull_mode),
    .pin_slew_lim(pin_slew_lim), .irq(irq), .irq_level(irq_level)
  );

  // {req, we, addr, wdata, expected read}
  localparam int NV = 43;
  localparam logic [25:0] VEC [NV] = '{
    {4'd2, 1'b1, 5'h00, 8'h3C, 8'h00}, {4'd2, 1'b0, 5'h00, 8'h00, 8'h3C},
    {4'd3, 1'b1, 5'h01, 8'hC0, 8'h00}, {4'd3, 1'b0, 5'h00, 8'h00, 8'hFC},
    {4'd3, 1'b0, 5'h01, 8'h00, 8'hFC}, {4'd3, 1'b1, 5'h02, 8'h0F, 8'h00},
    {4'd3, 1'b0, 5'h00, 8'h00, 8'hF0}, {4'd3, 1'b0, 5'h03, 8'h00, 8'hF0},
    {4'd3, 1'b1, 5'h03, 8'hFF, 8'h00}, {4'd3, 1'b0, 5'h00, 8'h00, 8'h0F},
    {4'd2, 1'b1, 5'h04, 8'h55, 8'h00}, {4'd2, 1'b0, 5'h04, 8'h00, 8'h55},
    {4'd3, 1'b1, 5'h05, 8'h0A, 8'h00}, {4'd3, 1'b0, 5'h04, 8'h00, 8'h5F},
    {4'd3, 1'b1, 5'h06, 8'h41, 8'h00}, {4'd3, 1'b0, 5'h04, 8'h00, 8'h1E},
    {4'd3, 1'b1, 5'h07, 8'hFF, 8'h00}, {4'd3, 1'b0, 5'h04, 8'h00, 8'hE1},
    {4'd3, 1'b0, 5'h07, 8'h00, 8'hE1}, {4'd8, 1'b1, 5'h09, 8'hFF, 8'h00},
    {4'd8, 1'b0, 5'h09, 8'h00, 8'h0F}, {4'd7, 1'b1, 5'h0C, 8'hFF, 8'h00},
    {4'd7, 1'b0, 5'h0C, 8'h00, 8'h00}, {4'd6, 1'b1, 5'h0A, 8'h81, 8'h00},
    {4'd6, 1'b0, 5'h0A, 8'h00, 8'h81}, {4'd6, 1'b1, 5'h0B, 8'h7E, 8'h00},
    {4'd6, 1'b0, 5'h0B, 8'h00, 8'h7E}, {4'd6, 1'b1, 5'h0A, 8'h00, 8'h00},
    {4'd6, 1'b1, 5'h0B, 8'h00, 8'h00}, {4'd8, 1'b1, 5'h09, 8'h00, 8'h00},
    {4'd8, 1'b0, 5'h09, 8'h00, 8'h00}, {4'd9, 1'b1, 5'h13, 8'hE9, 8'h00},
    {4'd9, 1'b0, 5'h13, 8'h00, 8'hE9}, {4'd9, 1'b0, 5'h17, 8'h00, 8'h00},
    {4'd4, 1'b0, 5'h08, 8'h00, 8'h08}, {4'd10, 1'b1, 5'h0D, 8'hAA, 8'h00},
    {4'd10, 1'b0, 5'h0D, 8'h00, 8'h00}, {4'd10, 1'b1, 5'h1F, 8'h55, 8'h00},
    {4'd10, 1'b0, 5'h1F, 8'h00, 8'h00}, {4'd10, 1'b1, 5'h08, 8'hFF, 8'h00},
    {4'd10, 1'b0, 5'h08, 8'h00, 8'h08}, {4'd10, 1'b1, 5'h0E, 8'h12, 8'h00},
    {4'd10, 1'b0, 5'h0E, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    for (int a = 0; a < 24; a++) begin
      rd(5'(a), r);
      check("R1 reset read", {24'b0, r}, 32'h0);
    end
    check("R1 pin_oe", {24'b0, pin_oe}, 32'h0);
    check("R1 pin_out", {24'b0, pin_out}, 32'h0);
    check("R1 irq", {30'b0, irq}, 32'h0);

    // table walk: R2 R3 R6 R7 R8 R9 R10 readback
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_we = VEC[i][21]; bus_addr = VEC[i][20:16]; bus_wdata = VEC[i][15:8];
      #1;
      if (!VEC[i][21]) begin
        n_chk++;
        if (bus_rdata !== VEC[i][7:0]) begin
          n_fail++;
          $display("FAIL R%0d row %0d actual %h expected %h", VEC[i][25:22], i, bus_rdata, VEC[i][7:0]);
        end
      end
    end
    @(negedge clk); bus_we = 1'b0;

    check("R2 pin_oe", {24'b0, pin_oe}, 32'h0F);
    check("R2 pin_out inverted bit3", {24'b0, pin_out}, 32'hE9);
    check("R9 pull mode pin3", {29'b0, pin_pull_mode[11:9]}, 32'h5);
    check("R9 pull mode other pins", {8'b0, pin_pull_mode & ~24'h000E00}, 32'h0);
    check("R9 slew", {24'b0, pin_slew_lim}, 32'h08);
    wr(5'h13, 8'h00); wr(5'h00, 8'h00); wr(5'h04, 8'h00);

    // R4 synchronizer latency, inversion, disable
    @(negedge clk); pin_in = 8'hA5;
    cyc(1); rd(5'h08, r); check("R4 one edge", {24'b0, r}, 32'h00);
    cyc(1); rd(5'h08, r); check("R4 two edges", {24'b0, r}, 32'hA5);
    wr(5'h10, 8'h40); rd(5'h08, r); check("R4 invert", {24'b0, r}, 32'hA4);
    wr(5'h12, 8'h07); wr(5'h15, 8'h05);
    rd(5'h08, r); check("R4 disabled reads 0", {24'b0, r}, 32'h80);
    wr(5'h10, 8'h00); wr(5'h12, 8'h00); wr(5'h15, 8'h00);
    @(negedge clk); pin_in = 8'h00;
    cyc(4);

    // R5 rising on channel 0
    wr(5'h0A, 8'h01); wr(5'h09, 8'h01); wr(5'h10, 8'h01); wr(5'h0C, 8'h03);
    pin_in = 8'h01;
    cyc(2); rd(5'h0C, r); check("R5 flag not early", {24'b0, r}, 32'h00);
    cyc(1); rd(5'h0C, r); check("R5 rising flag", {24'b0, r}, 32'h01);
    check("R8 irq0 on", {30'b0, irq}, 32'h1);
    wr(5'h0C, 8'h02); rd(5'h0C, r); check("R7 write 0 keeps flag", {24'b0, r}, 32'h01);
    wr(5'h0C, 8'h01); rd(5'h0C, r); check("R7 clear", {24'b0, r}, 32'h00);
    pin_in = 8'h00;
    cyc(4); rd(5'h0C, r); check("R5 rising ignores fall", {24'b0, r}, 32'h00);

    // R5 falling
    wr(5'h10, 8'h02); wr(5'h0C, 8'h03);
    pin_in = 8'h01;
    cyc(4); rd(5'h0C, r); check("R5 falling ignores rise", {24'b0, r}, 32'h00);
    pin_in = 8'h00;
    cyc(3); rd(5'h0C, r); check("R5 falling flag", {24'b0, r}, 32'h01);
    wr(5'h0C, 8'h01);

    // R5 any change, R8 level gate
    wr(5'h10, 8'h00);
    pin_in = 8'h01;
    cyc(3); rd(5'h0C, r); check("R5 any rise", {24'b0, r}, 32'h01);
    wr(5'h09, 8'h00);
    check("R8 level 0 gates irq", {30'b0, irq}, 32'h0);
    rd(5'h0C, r); check("R8 flag kept", {24'b0, r}, 32'h01);
    wr(5'h09, 8'h01); wr(5'h0C, 8'h01);
    pin_in = 8'h00;
    cyc(3); rd(5'h0C, r); check("R5 any fall", {24'b0, r}, 32'h01);
    wr(5'h0C, 8'h01);

    // R5 low level, R7 event beats clear
    wr(5'h10, 8'h03);
    cyc(2); rd(5'h0C, r); check("R5 low level", {24'b0, r}, 32'h01);
    wr(5'h0C, 8'h01); rd(5'h0C, r); check("R7 event wins", {24'b0, r}, 32'h01);
    pin_in = 8'h01;
    cyc(3); wr(5'h0C, 8'h01);
    rd(5'h0C, r); check("R7 clear after level gone", {24'b0, r}, 32'h00);

    // R6 masks, channel 1
    wr(5'h10, 8'h00); wr(5'h0B, 8'h02); wr(5'h09, 8'h09);
    cyc(3); wr(5'h0C, 8'h03);
    pin_in = 8'h09;
    cyc(4); rd(5'h0C, r); check("R6 unmasked pin", {24'b0, r}, 32'h00);
    pin_in = 8'h0B;
    cyc(3); rd(5'h0C, r); check("R6 channel 1 only", {24'b0, r}, 32'h02);
    check("R8 irq1", {30'b0, irq}, 32'h2);
    check("R8 irq_level", {28'b0, irq_level}, 32'h9);

    cyc(2);
    finish_run();
  end

endmodule